// File: doc/BRIEF.md
# Masked Supervisor Counter-Inhibit Alias

This block owns the machine-level counter-inhibit register: one stop bit for each of 32 hardware counters, exported as a vector to the counters themselves. Machine software reads and writes the whole register through its own port. Supervisor software sees the same register through a second port. That port is a live masked window: a bit is visible only when the matching bit of the counter-enable mask delegates that counter to the supervisor. Undelegated bits read as zero and keep their value when the supervisor writes them.

The supervisor port also reaches a second slot, the read-only 32-bit overflow-status word, which is supplied from outside. The block decides for every supervisor access whether it raises an illegal-instruction or a virtual-instruction exception. The decision uses the current privilege mode, the virtualization flag and the delegation-enable bit. An access that raises an exception neither writes nor returns data. Counting and interrupt generation live elsewhere.

Both access ports are plain register ports with no back-pressure. An access completes in the cycle it is presented. Read data and exception flags are combinational in that cycle, and a write takes effect at the next rising clock edge. The ports carry no valid/ready pair because the block can always accept an access.

Top module: `cnt_inhibit_alias`

## Requirements
- R1: After reset the stored inhibit vector, `m_rdata` and `inhibit_out` are all zero, and an idle supervisor port drives `s_rdata` = 0 with both exception flags low.
- R2: A machine write (`m_we`=1) loads all 32 bits from `m_wdata`, whatever the counter-enable mask is. Bit 1, the timer slot, is always stored as 0. The new value appears on `m_rdata` and `inhibit_out` after the next rising edge.
- R3: A granted supervisor read of slot 0 (`s_slot`=0) returns the stored vector ANDed with `cnt_en_mask` in the same cycle.
- R4: A granted supervisor write of slot 0 changes only the stored bits whose `cnt_en_mask` bit is 1. All other stored bits keep their value.
- R5: Changing `cnt_en_mask` never changes the stored inhibit bits. It only changes what the supervisor view shows.
- R6: Any supervisor access (read or write) to slot 0 raises `s_illegal` while `deleg_en`=0.
- R7: With `deleg_en`=1, a supervisor access to slot 0 raises `s_virtual` when the mode is virtualized. Virtualized means `virt`=1 and `priv` is not M (2'b11). A machine-mode access with `virt`=1 is not virtualized.
- R8: A supervisor read of slot 1 (`s_slot`=1) returns `ovf_status`. With `deleg_en`=1 in a virtualized mode, it raises `s_virtual` instead.
- R9: A supervisor write to slot 1 raises `s_illegal`. A non-virtualized access from user mode (`priv`=2'b00) to either slot raises `s_illegal`. The other privilege codes are 2'b01 for S and 2'b11 for M.
- R10: When an exception is raised, no supervisor write takes place and `s_rdata` is 0. At most one of `s_illegal` and `s_virtual` is high at any time.
- R11: When the machine and supervisor ports write in the same cycle, the machine write alone takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| virt | input | 1 | Virtualization flag (guest mode) |
| deleg_en | input | 1 | Counter delegation enable |
| cnt_en_mask | input | 32 | Per-counter delegation mask |
| ovf_status | input | 32 | Overflow-status word shown in slot 1 |
| m_we | input | 1 | Machine-level write strobe |
| m_wdata | input | 32 | Machine-level write data |
| m_rdata | output | 32 | Machine-level read data (full stored vector) |
| s_rd | input | 1 | Supervisor read strobe |
| s_we | input | 1 | Supervisor write strobe |
| s_slot | input | 1 | Supervisor target: 0 inhibit alias, 1 overflow status |
| s_wdata | input | 32 | Supervisor write data |
| s_rdata | output | 32 | Supervisor read data |
| s_illegal | output | 1 | Illegal-instruction exception for this access |
| s_virtual | output | 1 | Virtual-instruction exception for this access |
| inhibit_out | output | 32 | Inhibit vector to the counters |

## Verification
A corrupted stored bit shows on `m_rdata` and `inhibit_out` one edge after the write that caused it. If that bit is delegated, it also shows on `s_rdata` in the same cycle as the next supervisor read. A mask leak is the case that needs care. A supervisor write that reaches an undelegated bit is invisible through the supervisor view, so the bench reads the full vector on the machine port after each such write. A wrong exception decode appears combinationally in the very cycle of the access, both on the flags and on the zeroed read data.

// File: rtl/cia_pkg.sv
package cia_pkg;
  localparam int unsigned CNT_W = 32;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_R = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic {
    SLOT_INH = 1'b0,
    SLOT_OVF = 1'b1
  } slot_e;

  typedef struct packed {
    logic illegal;
    logic virt_exc;
    logic wr_ok;
    logic rd_ok;
  } guard_t;
endpackage

// File: rtl/cia_access_guard.sv
module cia_access_guard
  import cia_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       deleg_en,
  input  logic       s_rd,
  input  logic       s_we,
  input  logic       s_slot,
  output guard_t     verdict
);
  logic active;
  logic guest;
  logic user_bare;

  always_comb begin
    active    = s_rd | s_we;
    guest     = virt & (priv_e'(priv) != PRIV_M);
    user_bare = (priv_e'(priv) == PRIV_U) & ~guest;
    verdict   = '0;
    if (active) begin
      if (slot_e'(s_slot) == SLOT_INH) begin
        if (!deleg_en)      verdict.illegal  = 1'b1;
        else if (guest)     verdict.virt_exc = 1'b1;
        else if (user_bare) verdict.illegal  = 1'b1;
      end else begin
        if (s_we)                  verdict.illegal  = 1'b1;
        else if (deleg_en && guest) verdict.virt_exc = 1'b1;
        else if (user_bare)        verdict.illegal  = 1'b1;
      end
    end
    verdict.rd_ok = s_rd & ~verdict.illegal & ~verdict.virt_exc;
    verdict.wr_ok = s_we & (slot_e'(s_slot) == SLOT_INH)
                    & ~verdict.illegal & ~verdict.virt_exc;
  end
endmodule

// File: rtl/cia_inhibit_store.sv
module cia_inhibit_store #(
  parameter int unsigned        N       = 32,
  parameter logic [N-1:0]       HARD0   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         m_we,
  input  logic [N-1:0] m_wdata,
  input  logic         s_we_ok,
  input  logic [N-1:0] s_wdata,
  input  logic [N-1:0] s_mask,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (HARD0[i]) begin : g_zero
      assign q[i] = 1'b0;
    end else begin : g_ff
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     bit_q <= 1'b0;
        else if (m_we)                  bit_q <= m_wdata[i];
        else if (s_we_ok && s_mask[i])  bit_q <= s_wdata[i];
      end
      assign q[i] = bit_q;
    end
  end
endmodule

// File: rtl/cia_view_mux.sv
module cia_view_mux
  import cia_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] stored,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] ovf,
  input  logic         slot,
  input  logic         rd_ok,
  output logic [N-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      unique case (slot_e'(slot))
        SLOT_INH: rdata = stored & mask;
        SLOT_OVF: rdata = ovf;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cnt_inhibit_alias.sv
module cnt_inhibit_alias
  import cia_pkg::*;
#(
  parameter int unsigned N     = CNT_W,
  parameter logic [N-1:0] HARD0 = N'(2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   priv,
  input  logic         virt,
  input  logic         deleg_en,
  input  logic [N-1:0] cnt_en_mask,
  input  logic [N-1:0] ovf_status,
  input  logic         m_we,
  input  logic [N-1:0] m_wdata,
  output logic [N-1:0] m_rdata,
  input  logic         s_rd,
  input  logic         s_we,
  input  logic         s_slot,
  input  logic [N-1:0] s_wdata,
  output logic [N-1:0] s_rdata,
  output logic         s_illegal,
  output logic         s_virtual,
  output logic [N-1:0] inhibit_out
);
  guard_t       verdict;
  logic [N-1:0] stored;

  cia_access_guard u_guard (
    .priv     (priv),
    .virt     (virt),
    .deleg_en (deleg_en),
    .s_rd     (s_rd),
    .s_we     (s_we),
    .s_slot   (s_slot),
    .verdict  (verdict)
  );

  cia_inhibit_store #(.N(N), .HARD0(HARD0)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_we    (m_we),
    .m_wdata (m_wdata),
    .s_we_ok (verdict.wr_ok),
    .s_wdata (s_wdata),
    .s_mask  (cnt_en_mask),
    .q       (stored)
  );

  cia_view_mux #(.N(N)) u_view (
    .stored (stored),
    .mask   (cnt_en_mask),
    .ovf    (ovf_status),
    .slot   (s_slot),
    .rd_ok  (verdict.rd_ok),
    .rdata  (s_rdata)
  );

  assign m_rdata     = stored;
  assign inhibit_out = stored;
  assign s_illegal   = verdict.illegal;
  assign s_virtual   = verdict.virt_exc;
endmodule

// File: rtl/cia_checker.sv
module cia_checker #(
  parameter int unsigned  N     = 32,
  parameter logic [N-1:0] HARD0 = N'(2)
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   priv,
  input logic         virt,
  input logic         deleg_en,
  input logic [N-1:0] cnt_en_mask,
  input logic         m_we,
  input logic [N-1:0] m_wdata,
  input logic         s_rd,
  input logic         s_we,
  input logic         s_slot,
  input logic [N-1:0] s_rdata,
  input logic         s_illegal,
  input logic         s_virtual,
  input logic [N-1:0] inhibit_out
);
  // R2 / R11: machine write lands in full, timer slot forced low
  p_mwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |=> inhibit_out == ($past(m_wdata) & ~HARD0));

  // R2: hard-wired bits never set
  p_hard0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_out & HARD0) == '0);

  // R4 / R5: undelegated bits untouched by any non-machine cycle
  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !m_we |=> ((inhibit_out ^ $past(inhibit_out)) & ~$past(cnt_en_mask)) == '0);

  // R6: no delegation, alias access is illegal
  p_nodeleg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_rd || s_we) && !s_slot && !deleg_en) |-> s_illegal);

  // R7: guest access with delegation is a virtual-instruction exception
  p_guest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_rd || s_we) && !s_slot && deleg_en && virt && priv != 2'b11) |-> s_virtual);

  // R10: exception zeroes read data and suppresses the write
  p_exc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_illegal || s_virtual) |-> s_rdata == '0);

  p_exc_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_illegal || s_virtual) && !m_we) |=> $stable(inhibit_out));

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_illegal, s_virtual}));

  // R3: alias read never exposes undelegated bits
  p_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd && !s_slot) |-> (s_rdata & ~cnt_en_mask) == '0);
endmodule

bind cnt_inhibit_alias cia_checker #(.N(N), .HARD0(HARD0)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .priv        (priv),
  .virt        (virt),
  .deleg_en    (deleg_en),
  .cnt_en_mask (cnt_en_mask),
  .m_we        (m_we),
  .m_wdata     (m_wdata),
  .s_rd        (s_rd),
  .s_we        (s_we),
  .s_slot      (s_slot),
  .s_rdata     (s_rdata),
  .s_illegal   (s_illegal),
  .s_virtual   (s_virtual),
  .inhibit_out (inhibit_out)
);

// File: tb/sim_cnt_inhibit_alias.sv
module sim_cnt_inhibit_alias;
  localparam int N = 32;
  localparam logic [N-1:0] HW0 = 32'h0000_0002;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic [1:0]   priv;
  logic         virt, deleg_en, m_we, s_rd, s_we, s_slot;
  logic [N-1:0] cnt_en_mask, ovf_status, m_wdata, s_wdata;
  logic [N-1:0] m_rdata, s_rdata, inhibit_out;
  logic         s_illegal, s_virtual;

  cnt_inhibit_alias u0 (
    .clk(clk), .rst_n(rst_n), .priv(priv), .virt(virt), .deleg_en(deleg_en),
    .cnt_en_mask(cnt_en_mask), .ovf_status(ovf_status),
    .m_we(m_we), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .s_rd(s_rd), .s_we(s_we), .s_slot(s_slot), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_illegal(s_illegal), .s_virtual(s_virtual),
    .inhibit_out(inhibit_out)
  );

  typedef struct {
    string        req;
    logic [N-1:0] rdata;
    logic         ill;
    logic         vir;
    logic [N-1:0] full;
  } exp_t;

  exp_t         sb[$];
  int           checks = 0;
  int           fails  = 0;
  logic [N-1:0] model  = '0;
  bit           done   = 0;

  // Driver: present one access at a falling edge, queue the expectation
  task automatic access(input string req, input logic [1:0] p, input logic v,
                        input logic de, input logic [N-1:0] mk,
                        input logic mw, input logic [N-1:0] mwd,
                        input logic rd, input logic wr, input logic sl,
                        input logic [N-1:0] swd);
    exp_t e;
    logic guest, ubare, ill, vir;
    @(negedge clk);
    priv = p; virt = v; deleg_en = de; cnt_en_mask = mk;
    m_we = mw; m_wdata = mwd; s_rd = rd; s_we = wr; s_slot = sl; s_wdata = swd;
    guest = v && (p != 2'b11);
    ubare = (p == 2'b00) && !guest;
    ill = 0; vir = 0;
    if (rd || wr) begin
      if (!sl) begin
        if (!de) ill = 1; else if (guest) vir = 1; else if (ubare) ill = 1;
      end else begin
        if (wr) ill = 1; else if (de && guest) vir = 1; else if (ubare) ill = 1;
      end
    end
    e.req = req; e.ill = ill; e.vir = vir; e.full = model;
    e.rdata = (rd && !ill && !vir) ? (sl ? ovf_status : (model & mk)) : '0;
    sb.push_back(e);
    if (mw) model = mwd & ~HW0;
    else if (wr && !sl && !ill && !vir) model = ((model & ~mk) | (swd & mk)) & ~HW0;
  endtask

  task automatic idle(input string req);
    access(req, 2'b01, 0, 1, cnt_en_mask, 0, '0, 0, 0, 0, '0);
  endtask

  // Monitor: sample one ns after the falling edge, compare against the queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (s_rdata !== e.rdata || s_illegal !== e.ill || s_virtual !== e.vir ||
            m_rdata !== e.full || inhibit_out !== e.full) begin
          fails++;
          $display("FAIL %s: got rd=%h ill=%b vir=%b full=%h/%h exp rd=%h ill=%b vir=%b full=%h",
                   e.req, s_rdata, s_illegal, s_virtual, m_rdata, inhibit_out,
                   e.rdata, e.ill, e.vir, e.full);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; priv = 2'b01; virt = 0; deleg_en = 1; cnt_en_mask = '0;
    ovf_status = 32'hA5A5_0F0F; m_we = 0; m_wdata = '0; s_rd = 0; s_we = 0;
    s_slot = 0; s_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    idle("R1 reset");
    // R2: machine write of all ones with nothing delegated, bit 1 stays low
    access("R2 mwrite", 2'b11, 0, 1, '0, 1, 32'hFFFF_FFFF, 0, 0, 0, '0);
    idle("R2 mwrite visible");
    // R3: masked supervisor read
    access("R3 masked read", 2'b01, 0, 1, 32'h0000_00F0, 0, '0, 1, 0, 0, '0);
    access("R3 masked read 2", 2'b01, 0, 1, 32'h8000_0003, 0, '0, 1, 0, 0, '0);
    // R4: supervisor write only touches delegated bits
    access("R4 swrite", 2'b01, 0, 1, 32'h0000_00F0, 0, '0, 0, 1, 0, 32'h0);
    access("R4 swrite result", 2'b01, 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 0, '0);
    // R5: mask changes leave storage alone
    access("R5 mask clear", 2'b01, 0, 1, 32'h0, 0, '0, 1, 0, 0, '0);
    access("R5 mask restore", 2'b01, 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 0, '0);
    // R6 / R10: no delegation, illegal, write suppressed
    access("R6 nodeleg write", 2'b01, 0, 0, 32'hFFFF_FFFF, 0, '0, 1, 1, 0, 32'h0);
    access("R10 write suppressed", 2'b01, 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 0, '0);
    // R7: guest access, virtual exception; machine mode with virt flag is not a guest
    access("R7 VS write", 2'b01, 1, 1, 32'hFFFF_FFFF, 0, '0, 1, 1, 0, 32'h0);
    access("R7 VU read", 2'b00, 1, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 0, '0);
    access("R7 M with virt", 2'b11, 1, 1, 32'h0000_FFFF, 0, '0, 1, 0, 0, '0);
    // R8: overflow slot
    access("R8 ovf read", 2'b01, 0, 1, 32'h0, 0, '0, 1, 0, 1, '0);
    access("R8 ovf guest", 2'b01, 1, 1, 32'h0, 0, '0, 1, 0, 1, '0);
    access("R8 ovf guest nodeleg", 2'b01, 1, 0, 32'h0, 0, '0, 1, 0, 1, '0);
    // R9: overflow write and bare user access
    access("R9 ovf write", 2'b01, 0, 1, 32'hFFFF_FFFF, 0, '0, 0, 1, 1, 32'h0);
    access("R9 user inh", 2'b00, 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 1, 0, 32'h0);
    access("R9 user ovf", 2'b00, 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 1, '0);
    // R11: simultaneous writes, machine wins
    access("R11 both write", 2'b01, 0, 1, 32'hFFFF_FFFF, 1, 32'h1234_5678, 0, 1, 0, 32'hFFFF_FFFF);
    idle("R11 result");
    // R2: supervisor cannot set the timer slot either
    access("R2 swrite bit1", 2'b01, 0, 1, 32'hFFFF_FFFF, 0, '0, 0, 1, 0, 32'h0000_0002);
    access("R2 bit1 low", 2'b01, 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 0, '0);
    // R4: partial write over a mixed pattern
    access("R4 mixed", 2'b01, 0, 1, 32'h0F0F_0F0F, 0, '0, 0, 1, 0, 32'hFFFF_FFFF);
    access("R4 mixed result", 2'b01, 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 0, '0);
    idle("R1 idle port zero");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule